// File: doc/BRIEF.md
# Marker-bit UART transmitter

This block serialises one byte at a time onto an asynchronous line. Each frame has ten bit times: a low start bit, the eight data bits with the least significant bit first, and a high stop level. Bytes arrive on a valid/ready stream port. Bit timing comes from a free-running 16x oversampling tick that is supplied from outside. The block divides that tick by sixteen with its own counter, which never restarts. Every bit boundary falls on a rollover of this counter, so the first bit does not start at the moment of the write.

The block needs no bit counter to find the end of a frame. A 1 is loaded one position above the data MSB. Every shift moves the register right and fills zeros in from the left. When only the marker remains just above the MSB, one last shift ends the frame. A sticky completion flag then rises and stays high until the `done_clr` input clears it.

Back-pressure rules: a transfer happens in a cycle in which `s_valid` and `s_ready` are both high. `s_ready` is high only while no frame is pending or in progress. It falls in the cycle after a transfer and rises again in the cycle after the frame's final rollover. While `s_ready` is low, `s_valid` and `s_data` have no effect. The line output `tx` is decoded directly from registered state.

Top module: `utx_marker_tx`

## Requirements
- R1: After reset, `tx` is 1, `tx_done` is 0 and `s_ready` is 1. `tx` is 1 whenever `s_ready` is 1.
- R2: A frame puts on `tx` a 0, then `s_data` bits 0 through 7 in that order, then 1. Each level lasts one rollover period of 16 `baud_tick` pulses.
- R3: A byte is taken in the cycle in which `s_valid` and `s_ready` are both high. `s_ready` is 0 in the following cycle.
- R4: `tx` stays 1 until the first divider rollover strictly after the accepting clock edge. The start bit begins at that rollover, including when the accepting edge is itself a rollover.
- R5: `tx` changes value only in the cycle that follows a divider rollover. A rollover is the 16th `baud_tick` counted since reset, and every 16th tick after it.
- R6: `tx_done` rises at the 10th rollover after the accepting edge, in the same cycle in which `tx` returns to 1. It is 0 during the last data bit.
- R7: `tx_done` stays 1 until `done_clr` is high at a clock edge. If setting and clearing fall on the same edge, setting wins.
- R8: A byte offered while a frame is in progress is not taken. The frame in progress keeps its original bits, and no further frame follows.
- R9: `s_ready` is 1 again in the cycle after the 10th rollover, so a following byte can be accepted at once.
- R10: The divider runs freely from reset and is never restarted by writes. Start latency therefore depends on the phase of the write relative to the divider.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | 16x oversampling tick, one cycle wide |
| s_valid | input | 1 | Byte offered |
| s_ready | output | 1 | Byte can be taken |
| s_data | input | DATA_W | Byte to send |
| done_clr | input | 1 | Clears the completion flag |
| tx | output | 1 | Serial line, idles high |
| tx_done | output | 1 | Sticky frame-complete flag |

## Verification
Several byte patterns are sent:
- 0xA5 and 0x96 catch swapped or misordered bits.
- 0x01 and 0x80 catch an off-by-one in the position of the MSB.
- 0x00 leaves only the marker bit set, so an end-of-frame test that looks for any set bit would stop early.
- 0xFF catches a zero-fill that turns into a one-fill.

The writes land at different phases of the divider, including exactly on a rollover edge. This separates rollover-aligned starts from write-aligned starts. One frame is sent with a competing byte offered in the middle of it. Another is sent with the clear held high across the completion edge.

// File: rtl/utx_pkg.sv
package utx_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_PEND  = 2'd1,
    PH_START = 2'd2,
    PH_DATA  = 2'd3
  } utx_phase_e;
endpackage

// File: rtl/utx_bit_timer.sv
// Free-running divider of the oversampling tick; pulses roll on the last tick of each bit time.
module utx_bit_timer #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic baud_tick,
  output logic roll
);
  localparam int CW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (baud_tick) begin
      if (cnt_q == LAST) cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign roll = baud_tick && (cnt_q == LAST);
endmodule

// File: rtl/utx_shifter.sv
// Data plus marker shift register; zero fill from the top.
module utx_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  input  logic              shift,
  output logic              lsb,
  output logic              last,
  output logic              empty
);
  localparam int SW = DATA_W + 1;
  localparam logic [SW-2:0] MARK_ONLY = {{(SW-2){1'b0}}, 1'b1};

  logic [SW-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (load) begin
      sr_q <= {1'b1, din};
    end else if (shift) begin
      sr_q <= {1'b0, sr_q[SW-1:1]};
    end
  end

  assign lsb   = sr_q[0];
  // marker directly above the bit at the output, nothing else above it
  assign last  = (sr_q[SW-1:1] == MARK_ONLY);
  assign empty = (sr_q == '0);
endmodule

// File: rtl/utx_tx_ctrl.sv
// Phase sequencing, line decode and the sticky completion flag.
module utx_tx_ctrl
  import utx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic       roll,
  input  logic       last,
  input  logic       lsb,
  input  logic       done_clr,
  output logic       shift,
  output logic       busy,
  output logic       tx,
  output logic       done
);
  utx_phase_e ph_q, ph_d;
  logic       done_q;
  logic       finish;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE:  if (accept) ph_d = PH_PEND;
      PH_PEND:  if (roll)   ph_d = PH_START;
      PH_START: if (roll)   ph_d = PH_DATA;
      PH_DATA:  if (roll && last) ph_d = PH_IDLE;
      default:  ph_d = PH_IDLE;
    endcase
  end

  assign shift  = (ph_q == PH_DATA) && roll;
  assign finish = shift && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      done_q <= 1'b0;
    end else begin
      ph_q <= ph_d;
      if (finish)        done_q <= 1'b1;
      else if (done_clr) done_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (ph_q)
      PH_START: tx = 1'b0;
      PH_DATA:  tx = lsb;
      default:  tx = 1'b1;
    endcase
  end

  assign busy = (ph_q != PH_IDLE);
  assign done = done_q;
endmodule

// File: rtl/utx_marker_tx.sv
module utx_marker_tx #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              done_clr,
  output logic              tx,
  output logic              tx_done
);
  logic roll_w, shift_w, last_w, lsb_w, empty_w, busy_w, accept_w;

  assign s_ready  = !busy_w;
  assign accept_w = s_valid && s_ready;

  utx_bit_timer #(.OVS(OVS)) u_timer (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .roll(roll_w)
  );

  utx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(accept_w), .din(s_data),
    .shift(shift_w), .lsb(lsb_w), .last(last_w), .empty(empty_w)
  );

  utx_tx_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .accept(accept_w), .roll(roll_w),
    .last(last_w), .lsb(lsb_w), .done_clr(done_clr),
    .shift(shift_w), .busy(busy_w), .tx(tx), .done(tx_done)
  );
endmodule

// File: rtl/utx_marker_tx_chk.sv
module utx_marker_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic roll,
  input logic sr_empty,
  input logic s_valid,
  input logic s_ready,
  input logic tx,
  input logic tx_done,
  input logic done_clr
);
  a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> tx);

  a_r3_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready);

  a_r2_marker_present: assert property (@(posedge clk) disable iff (!rst_n)
    !s_ready |-> !sr_empty);

  a_r5_edge_on_rollover: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tx) |-> $past(roll));

  a_r6_done_on_rollover: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done) |-> $past(roll));

  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && !done_clr) |=> tx_done);
endmodule

bind utx_marker_tx utx_marker_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .roll(roll_w), .sr_empty(empty_w),
  .s_valid(s_valid), .s_ready(s_ready), .tx(tx), .tx_done(tx_done),
  .done_clr(done_clr)
);

// File: tb/utx_marker_tx_tb.sv
`timescale 1ns/1ps
module utx_marker_tx_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick;
  logic       s_valid = 1'b0;
  logic       s_ready;
  logic [7:0] s_data = '0;
  logic       done_clr = 1'b0;
  logic       tx;
  logic       tx_done;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  utx_marker_tx u_dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .s_valid(s_valid),
    .s_ready(s_ready), .s_data(s_data), .done_clr(done_clr),
    .tx(tx), .tx_done(tx_done)
  );

  // tick source: one pulse every 4 clocks
  logic [1:0] tdiv;
  always @(posedge clk) begin
    if (!rst_n) begin
      tdiv <= '0; baud_tick <= 1'b0;
    end else begin
      tdiv <= tdiv + 1'b1;
      baud_tick <= (tdiv == 2'd3);
    end
  end

  // bench's own model of the bit-time grid (R5, R10)
  logic [3:0] tk;
  int roll_count;
  always @(posedge clk) begin
    if (!rst_n) begin
      tk <= '0; roll_count <= 0;
    end else if (baud_tick) begin
      tk <= tk + 1'b1;
      if (tk == 4'd15) roll_count <= roll_count + 1;
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    finish_run();
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_roll(input int n);
    while (roll_count < n) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(tx === 1'b1, "R1", "tx after reset", int'(tx), 1);
    chk(tx_done === 1'b0, "R1", "done after reset", int'(tx_done), 0);
    chk(s_ready === 1'b1, "R1", "ready after reset", int'(s_ready), 1);
  endtask

  task automatic run_frame(input logic [7:0] b, input int pre_wait,
                           input bit aim_roll, input bit intrude,
                           input bit clr_across);
    int r0;
    bit lat_bad;
    bit rdy_bad;
    if (tx_done) begin
      done_clr = 1'b1; @(negedge clk); done_clr = 1'b0;
    end
    repeat (pre_wait) @(negedge clk);
    // R4/R10: place the accepting edge exactly on a rollover
    if (aim_roll) while (!(baud_tick && tk == 4'd15)) @(negedge clk);
    chk(s_ready === 1'b1, "R3", "ready before write", int'(s_ready), 1);
    s_valid = 1'b1; s_data = b;
    @(negedge clk);
    s_valid = 1'b0; s_data = 8'h5A;
    r0 = roll_count;
    chk(s_ready === 1'b0, "R3", "ready after accept", int'(s_ready), 0);
    lat_bad = 1'b0;
    while (roll_count == r0) begin
      if (tx !== 1'b1) lat_bad = 1'b1;
      @(negedge clk);
    end
    chk(!lat_bad, "R4", "line low before first rollover", int'(lat_bad), 0);
    chk(tx === 1'b0, "R4", "start bit at first rollover", int'(tx), 0);
    for (int i = 0; i < 8; i++) begin
      wait_roll(r0 + 2 + i);
      chk(tx === b[i], "R2", $sformatf("data bit %0d of %02h", i, b), int'(tx), int'(b[i]));
      if (intrude && i == 3) begin
        rdy_bad = 1'b0;
        s_valid = 1'b1; s_data = ~b;
        for (int k = 0; k < 40; k++) begin
          @(negedge clk);
          if (s_ready !== 1'b0) rdy_bad = 1'b1;
        end
        s_valid = 1'b0;
        chk(!rdy_bad, "R8", "ready stays low mid-frame", int'(rdy_bad), 0);
      end
      if (i == 7) begin
        chk(tx_done === 1'b0, "R6", "done not early", int'(tx_done), 0);
        if (clr_across) done_clr = 1'b1;
      end
    end
    wait_roll(r0 + 10);
    chk(tx === 1'b1, "R2", "stop level", int'(tx), 1);
    chk(tx_done === 1'b1, clr_across ? "R7" : "R6", "done at 10th rollover", int'(tx_done), 1);
    chk(s_ready === 1'b1, "R9", "ready after frame", int'(s_ready), 1);
    if (clr_across) begin
      @(negedge clk);
      chk(tx_done === 1'b0, "R7", "clear after set", int'(tx_done), 0);
      done_clr = 1'b0;
    end
    if (intrude) begin
      wait_roll(r0 + 12);
      chk(tx === 1'b1 && s_ready === 1'b1, "R8", "no frame from ignored byte",
          int'(tx), 1);
    end
  endtask

  task automatic t_sticky();
    repeat (200) @(negedge clk);
    chk(tx_done === 1'b1, "R7", "done held", int'(tx_done), 1);
    done_clr = 1'b1; @(negedge clk); done_clr = 1'b0;
    chk(tx_done === 1'b0, "R7", "done cleared", int'(tx_done), 0);
    done_clr = 1'b1; @(negedge clk); done_clr = 1'b0;
    chk(tx_done === 1'b0 && tx === 1'b1, "R7", "clear while clear", int'(tx_done), 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_frame(8'hA5, 3, 1'b0, 1'b0, 1'b0);
    run_frame(8'h01, 0, 1'b1, 1'b0, 1'b0);   // R10 write on rollover
    run_frame(8'h80, 17, 1'b0, 1'b0, 1'b0);  // R10 other phase
    run_frame(8'h00, 0, 1'b0, 1'b0, 1'b0);
    run_frame(8'hFF, 5, 1'b0, 1'b0, 1'b0);
    run_frame(8'h3C, 2, 1'b0, 1'b1, 1'b0);   // R8
    t_sticky();
    run_frame(8'h96, 1, 1'b0, 1'b0, 1'b1);   // R7 priority
    finish_run();
  end
endmodule